// File: doc/BRIEF.md
# Two-Register Stack ALU Datapath

This block is the data path of a small stack processor. It holds two words: the top of stack `t_out` and the entry beneath it `n_out`. Each clock edge can rewrite either or both. The top register takes one of four sources: the function unit result, the second register, the zero-extended switch value, or a literal word. The second register can only take the old top value. The two load strobes and the source select together express the stack operations:

- push: load both, so the old top moves down;
- DUP: load the second register only;
- SWAP: load both with the second-register source.

The function unit is steered by a 6-bit code. It covers add and subtract, increment and decrement, bitwise logic, single-bit shifts (logical and arithmetic), shifts of the second word by a count held in the top word, and the constants TRUE and FALSE. It also covers twelve comparisons, each of which gives an all-ones or all-zeros flag. Binary operations take the second word as the left operand (second minus top, for example). Unary operations act on the top word alone. A sequencer outside the block decodes instructions and drives the strobes. The top word also feeds a display and branch tests.

Top module: `stack_alu_dp`

## Requirements
- R1: While `clr` is high, both `t_out` and `n_out` are 0, independent of the clock.
- R2: With `t_load` low, `t_out` keeps its value across a clock edge. With `n_load` low, `n_out` keeps its value.
- R3: With `n_load` high, `n_out` takes the value `t_out` had before the edge (DUP alone, or the push half of a push or swap).
- R4: With `t_load` high, `t_src` selects the new top: 0 = function result, 1 = old `n_out`, 2 = switches, 3 = `lit`. Loading both with `t_src`=1 exchanges the two words.
- R5: Source 2 loads the 8-bit `sw` zero-extended into `t_out`.
- R6: Arithmetic codes: 0x10 gives N+T, 0x11 gives N−T, 0x12 gives T+1, 0x13 gives T−1. All are modulo 2^16.
- R7: Logic and constant codes: 0x14 gives ~T, 0x15 gives N&T, 0x16 gives N|T, 0x17 gives N^T, 0x20 gives 0xFFFF, 0x21 gives 0x0000.
- R8: Shift codes:
  - 0x18 gives T<<1.
  - 0x19 gives T>>1, filling with zero.
  - 0x1A gives T>>1 and keeps bit 15.
  - 0x1B gives N shifted right logically by T.
  - 0x1C gives N shifted left by T.
  - For 0x1B and 0x1C, a count of 16 or more gives 0.
- R9: Comparison codes give 0xFFFF when true and 0x0000 when false:
  - On T alone: 0x22 is T==0, and 0x23 is T<0 signed.
  - Unsigned, N against T: 0x24 is N>T, 0x25 is N<T, 0x27 is N>=T, 0x28 is N<=T.
  - Equality: 0x26 is N==T, and 0x29 is N!=T.
  - Signed two's complement, N against T: 0x2A is N>T, 0x2B is N<T, 0x2C is N>=T, 0x2D is N<=T.
- R10: Any code not listed above, loaded with source 0, leaves `t_out` unchanged.
- R11: From a pushed value v, the code sequence 2*, DUP, 2*, 2*, + leaves 10·v in `t_out` (0x3B gives 0x24E).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| clr | input | 1 | Asynchronous clear, active high |
| t_load | input | 1 | Load the top register this edge |
| n_load | input | 1 | Load the second register from the old top |
| t_src | input | 2 | Top source: 0 function, 1 second, 2 switches, 3 literal |
| fn | input | 6 | Function code |
| sw | input | 8 | Switch value |
| lit | input | 16 | Literal word |
| t_out | output | 16 | Top of stack |
| n_out | output | 16 | Second stack entry |

## Verification
Directed cases target the values where a mistake shows up:
- Signed against unsigned comparisons use 0x8000 and 0x7FFF, which order oppositely under the two readings.
- Halving uses operands with the sign bit set, which separates a zero fill from a sign fill.
- Shift counts of 0, 15, 16 and 0xFFFF catch wrong saturation.
- Equal operands separate strict from non-strict comparisons.

Random words under random strobes and sources then check that operand order (N op T) and the hold and push paths stay right across all codes, including undefined ones. The multiply-by-ten sequence ties DUP and the function codes together end to end.

// File: rtl/stack_alu_dp.sv
module stack_alu_dp #(
  parameter int W    = 16,
  parameter int SW_W = 8
) (
  input  logic            clk,
  input  logic            clr,
  input  logic            t_load,
  input  logic            n_load,
  input  logic [1:0]      t_src,
  input  logic [5:0]      fn,
  input  logic [SW_W-1:0] sw,
  input  logic [W-1:0]    lit,
  output logic [W-1:0]    t_out,
  output logic [W-1:0]    n_out
);
  localparam logic [W-1:0] ONES = {W{1'b1}};
  localparam logic [W-1:0] ZERO = '0;

  logic [W-1:0] t_q, n_q, fres, t_nxt;
  logic         flag, is_cmp;

  assign t_out = t_q;
  assign n_out = n_q;

  always_comb begin
    flag   = 1'b0;
    is_cmp = 1'b1;
    case (fn)
      6'h22: flag = (t_q == ZERO);
      6'h23: flag = t_q[W-1];
      6'h24: flag = (n_q > t_q);
      6'h25: flag = (n_q < t_q);
      6'h26: flag = (n_q == t_q);
      6'h27: flag = (n_q >= t_q);
      6'h28: flag = (n_q <= t_q);
      6'h29: flag = (n_q != t_q);
      6'h2A: flag = ($signed(n_q) >  $signed(t_q));
      6'h2B: flag = ($signed(n_q) <  $signed(t_q));
      6'h2C: flag = ($signed(n_q) >= $signed(t_q));
      6'h2D: flag = ($signed(n_q) <= $signed(t_q));
      default: is_cmp = 1'b0;
    endcase
  end

  always_comb begin
    fres = t_q;
    if (is_cmp) fres = flag ? ONES : ZERO;
    else case (fn)
      6'h10: fres = n_q + t_q;
      6'h11: fres = n_q - t_q;
      6'h12: fres = t_q + 1'b1;
      6'h13: fres = t_q - 1'b1;
      6'h14: fres = ~t_q;
      6'h15: fres = n_q & t_q;
      6'h16: fres = n_q | t_q;
      6'h17: fres = n_q ^ t_q;
      6'h18: fres = {t_q[W-2:0], 1'b0};
      6'h19: fres = {1'b0, t_q[W-1:1]};
      6'h1A: fres = {t_q[W-1], t_q[W-1:1]};
      6'h1B: fres = n_q >> t_q;
      6'h1C: fres = n_q << t_q;
      6'h20: fres = ONES;
      6'h21: fres = ZERO;
      default: fres = t_q;
    endcase
  end

  always_comb begin
    case (t_src)
      2'd0: t_nxt = fres;
      2'd1: t_nxt = n_q;
      2'd2: t_nxt = {{(W-SW_W){1'b0}}, sw};
      default: t_nxt = lit;
    endcase
  end

  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      t_q <= '0;
      n_q <= '0;
    end else begin
      if (t_load) t_q <= t_nxt;
      if (n_load) n_q <= t_q;
    end
  end
endmodule

// File: rtl/stack_alu_dp_chk.sv
module stack_alu_dp_chk #(
  parameter int W    = 16,
  parameter int SW_W = 8
) (
  input logic            clk,
  input logic            clr,
  input logic            t_load,
  input logic            n_load,
  input logic [1:0]      t_src,
  input logic [5:0]      fn,
  input logic [SW_W-1:0] sw,
  input logic [W-1:0]    lit,
  input logic [W-1:0]    t_out,
  input logic [W-1:0]    n_out
);
  p_clear_r1: assert property (@(posedge clk) clr |-> (t_out == '0 && n_out == '0));

  p_t_hold_r2: assert property (@(posedge clk) disable iff (clr)
    !t_load |=> $stable(t_out));

  p_n_hold_r2: assert property (@(posedge clk) disable iff (clr)
    !n_load |=> $stable(n_out));

  p_n_push_r3: assert property (@(posedge clk) disable iff (clr)
    n_load |=> n_out == $past(t_out));

  p_swap_r4: assert property (@(posedge clk) disable iff (clr)
    (t_load && t_src == 2'd1) |=> t_out == $past(n_out));

  p_lit_r4: assert property (@(posedge clk) disable iff (clr)
    (t_load && t_src == 2'd3) |=> t_out == $past(lit));

  p_sw_zext_r5: assert property (@(posedge clk) disable iff (clr)
    (t_load && t_src == 2'd2) |=> t_out == {{(W-SW_W){1'b0}}, $past(sw)});

  p_flag_r9: assert property (@(posedge clk) disable iff (clr)
    (t_load && t_src == 2'd0 && fn >= 6'h22 && fn <= 6'h2D)
      |=> (t_out == '0 || t_out == {W{1'b1}}));
endmodule

bind stack_alu_dp stack_alu_dp_chk #(.W(W), .SW_W(SW_W)) i_chk (
  .clk(clk), .clr(clr), .t_load(t_load), .n_load(n_load), .t_src(t_src),
  .fn(fn), .sw(sw), .lit(lit), .t_out(t_out), .n_out(n_out)
);

// File: tb/test_stack_alu_dp.sv
module test_stack_alu_dp;
  logic        clk = 0, clr = 1, t_load = 0, n_load = 0;
  logic [1:0]  t_src = 0;
  logic [5:0]  fn = 0;
  logic [7:0]  sw = 0;
  logic [15:0] lit = 0, t_out, n_out;
  logic [15:0] mt = 0, mn = 0;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  stack_alu_dp i_stack_alu_dp (.*);

  function automatic logic [15:0] fexp(input logic [5:0] f, input logic [15:0] t, input logic [15:0] n);
    logic signed [15:0] st = t, sn = n;
    case (f)
      6'h10: return n + t;
      6'h11: return n - t;
      6'h12: return t + 16'd1;
      6'h13: return t - 16'd1;
      6'h14: return ~t;
      6'h15: return n & t;
      6'h16: return n | t;
      6'h17: return n ^ t;
      6'h18: return t * 16'd2;
      6'h19: return t / 16'd2;
      6'h1A: return {t[15], t[15:1]};
      6'h1B: return (t >= 16) ? 16'h0 : n >> t[3:0];
      6'h1C: return (t >= 16) ? 16'h0 : n << t[3:0];
      6'h20: return 16'hFFFF;
      6'h21: return 16'h0000;
      6'h22: return (t == 0) ? 16'hFFFF : 16'h0;
      6'h23: return (st < 0) ? 16'hFFFF : 16'h0;
      6'h24: return (n > t) ? 16'hFFFF : 16'h0;
      6'h25: return (n < t) ? 16'hFFFF : 16'h0;
      6'h26: return (n == t) ? 16'hFFFF : 16'h0;
      6'h27: return (n >= t) ? 16'hFFFF : 16'h0;
      6'h28: return (n <= t) ? 16'hFFFF : 16'h0;
      6'h29: return (n != t) ? 16'hFFFF : 16'h0;
      6'h2A: return (sn > st) ? 16'hFFFF : 16'h0;
      6'h2B: return (sn < st) ? 16'hFFFF : 16'h0;
      6'h2C: return (sn >= st) ? 16'hFFFF : 16'h0;
      6'h2D: return (sn <= st) ? 16'hFFFF : 16'h0;
      default: return t;
    endcase
  endfunction

  function automatic string ftag(input logic [5:0] f);
    if (f >= 6'h10 && f <= 6'h13) return "R6";
    if ((f >= 6'h14 && f <= 6'h17) || f == 6'h20 || f == 6'h21) return "R7";
    if (f >= 6'h18 && f <= 6'h1C) return "R8";
    if (f >= 6'h22 && f <= 6'h2D) return "R9";
    return "R10";
  endfunction

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(input logic tl, input logic nl, input logic [1:0] src,
                      input logic [5:0] f, input logic [7:0] s, input logic [15:0] l);
    logic [15:0] sel, et, en;
    string tt, tn;
    @(negedge clk);
    t_load = tl; n_load = nl; t_src = src; fn = f; sw = s; lit = l;
    case (src)
      2'd0: sel = fexp(f, mt, mn);
      2'd1: sel = mn;
      2'd2: sel = {8'h0, s};
      default: sel = l;
    endcase
    et = tl ? sel : mt;
    en = nl ? mt : mn;
    tt = !tl ? "R2" : (src == 2'd0) ? ftag(f) : (src == 2'd2) ? "R5" : "R4";
    tn = nl ? "R3" : "R2";
    @(negedge clk);
    t_load = 0; n_load = 0;
    mt = et; mn = en;
    chk(tt, t_out, et);
    chk(tn, n_out, en);
  endtask

  task automatic setup(input logic [15:0] n, input logic [15:0] t);
    step(1, 0, 2'd3, 0, 0, n);
    step(1, 1, 2'd3, 0, 0, t);
  endtask

  localparam logic [5:0] CODES [27] = '{6'h10, 6'h11, 6'h12, 6'h13, 6'h14, 6'h15,
    6'h16, 6'h17, 6'h18, 6'h19, 6'h1A, 6'h1B, 6'h1C, 6'h20, 6'h21, 6'h22, 6'h23,
    6'h24, 6'h25, 6'h26, 6'h27, 6'h28, 6'h29, 6'h2A, 6'h2B, 6'h2C, 6'h2D};

  initial begin
    void'($urandom(32'h5eed_1234));
    #3;
    chk("R1", t_out, 16'h0);
    chk("R1", n_out, 16'h0);
    @(negedge clk); clr = 0;

    // R11 ten-times sequence
    step(1, 1, 2'd2, 0, 8'h3B, 0);
    step(1, 0, 2'd0, 6'h18, 0, 0);
    step(0, 1, 2'd0, 0, 0, 0);
    step(1, 0, 2'd0, 6'h18, 0, 0);
    step(1, 0, 2'd0, 6'h18, 0, 0);
    step(1, 0, 2'd0, 6'h10, 0, 0);
    chk("R11", t_out, 16'h024E);

    // R4 swap
    setup(16'h1111, 16'h2222);
    step(1, 1, 2'd1, 0, 0, 0);
    chk("R4", t_out, 16'h1111);
    chk("R4", n_out, 16'h2222);

    // R9 signed vs unsigned edges
    for (int k = 6'h22; k <= 6'h2D; k++) begin
      setup(16'h8000, 16'h7FFF); step(1, 0, 2'd0, k[5:0], 0, 0);
      setup(16'h5A5A, 16'h5A5A); step(1, 0, 2'd0, k[5:0], 0, 0);
      setup(16'h7FFF, 16'h0000); step(1, 0, 2'd0, k[5:0], 0, 0);
    end
    // R8 halving and shift counts
    setup(16'h0, 16'h8001); step(1, 0, 2'd0, 6'h19, 0, 0);
    setup(16'h0, 16'h8001); step(1, 0, 2'd0, 6'h1A, 0, 0);
    foreach (CODES[i]) if (CODES[i] == 6'h1B || CODES[i] == 6'h1C) begin
      setup(16'hC3A5, 16'd0);  step(1, 0, 2'd0, CODES[i], 0, 0);
      setup(16'hC3A5, 16'd15); step(1, 0, 2'd0, CODES[i], 0, 0);
      setup(16'hC3A5, 16'd16); step(1, 0, 2'd0, CODES[i], 0, 0);
      setup(16'hC3A5, 16'hFFFF); step(1, 0, 2'd0, CODES[i], 0, 0);
    end
    // R10 undefined codes
    setup(16'h1234, 16'hBEEF);
    step(1, 0, 2'd0, 6'h00, 0, 0);
    step(1, 0, 2'd0, 6'h1F, 0, 0);
    step(1, 0, 2'd0, 6'h3F, 0, 0);

    // random mix
    for (int i = 0; i < 1500; i++) begin
      logic [5:0] f;
      f = ($urandom % 8 == 0) ? 6'($urandom) : CODES[$urandom % 27];
      step(1'($urandom), 1'($urandom), 2'($urandom), f, 8'($urandom), 16'($urandom));
    end

    // R1 asynchronous clear mid-cycle
    setup(16'hAAAA, 16'h5555);
    #2 clr = 1; #1;
    chk("R1", t_out, 16'h0);
    chk("R1", n_out, 16'h0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule